// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is the master side of a serial peripheral link. Software places one word in a holding register. The engine copies that word into its shift register as soon as the shift register is free. It then clocks the word out on MOSI and, at the same time, collects a word from MISO. The received word is stored in a receive register when the final clock edge of the frame arrives. Because the holding register is free again as soon as the copy happens, software can queue the next word while the current one is still on the wire. A queued word follows the current one with no idle clock period between them.

The serial clock is the system clock divided by a power of two, from 2 up to `2^(2^PSC_W)`. Clock idle level, sampling edge and bit order are set in a configuration register. That register accepts writes only while the engine is disabled. Three flags report progress:

- the holding register is empty;
- a received word is waiting to be read;
- a frame is in progress.

A frame is complete, and chip select may be released, only when the receive flag is set and the busy flag is low. The empty flag alone does not mean the frame is done. Chip select is a plain software-controlled output.

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, `tx_empty` is 1, `rx_full` is 0 and `busy` is 0.
- R2: Whenever no frame is in progress, `sck` rests at the configured idle level: 0 for `cfg_cpol`=0 and 1 for `cfg_cpol`=1.
- R3: Consecutive SCK edges are exactly `2^cfg_psc` system clocks apart, so the SCK period is `2^(cfg_psc+1)` clocks. For example, `cfg_psc`=0 gives divide-by-2 and `cfg_psc`=7 gives divide-by-256.
- R4: With `cfg_cpha`=0, both sides sample on odd edges (1st, 3rd, …), and bit 0 of the frame is on MOSI before the first edge. With `cfg_cpha`=1, both sides sample on even edges and MOSI changes on odd edges. A frame has 16 edges.
- R5: With `cfg_lsb_first`=0, data bit 7 goes first on the wire. With `cfg_lsb_first`=1, bit 0 goes first. The received word is assembled in the same order.
- R6: Every frame is full duplex. The 8 bits sampled from MISO appear on `rx_data` when the frame's last edge arrives.
- R7: `tx_empty` rises in the cycle the held word is copied into the shift register. At that moment `busy` is already 1 and no SCK edge of that frame has happened yet.
- R8: When a frame ends with no word queued, `busy` falls in the same cycle that `rx_full` is set, and `sck` is back at its idle level.
- R9: A word written while a frame is in progress is loaded on that frame's last edge. Its first edge follows one half period later, and `busy` stays 1 across the boundary.
- R10: Writing `tx_data` clears `tx_empty` on the next cycle. Pulsing `rx_re` clears `rx_full` on the next cycle. A new word arriving in the same cycle as `rx_re` keeps `rx_full` set.
- R11: A configuration write while `en` is 1 is ignored. The SCK idle level and the SCK rate keep their previous values.
- R12: `cs_n` is the inverse of `cs_sel`, registered, so it changes one cycle after `cs_sel`.
- R13: Dropping `en` during a frame abandons that frame. On the next cycle `busy` is 0 and `sck` is at its idle level, and the word already moved into the shift register is not returned to the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Engine enable; 0 aborts a frame and unlocks configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on odd edges, 1: sample on even edges |
| cfg_lsb_first | input | 1 | 1: bit 0 first on the wire |
| cfg_psc | input | PSC_W | Prescaler exponent; SCK = clk / 2^(cfg_psc+1) |
| tx_we | input | 1 | Holding-register write strobe |
| tx_data | input | WORD_W | Word to transmit |
| rx_re | input | 1 | Receive-register read strobe |
| rx_data | output | WORD_W | Last received word |
| cs_sel | input | 1 | Software chip-select request, 1 selects the slave |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| miso | input | 1 | Serial data from slave |
| tx_empty | output | 1 | Holding register can accept a word |
| rx_full | output | 1 | Unread word in `rx_data` |
| busy | output | 1 | Frame in progress |

## Verification
The bench builds the block with its default `WORD_W`=8 and `PSC_W`=3. This gives eight prescaler settings, from divide-by-2 up to divide-by-256. Both extremes are exercised, so the tightest case is covered: one clock per SCK half period, where MISO must settle within a single cycle. The longest frame, 2048 clocks, is also covered. With the narrow exponent field, all four clock modes, both bit orders and back-to-back pairs fit in a short table. Edge spacing is measured across word boundaries, so a gap between queued words shows up as a spacing error.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;

   // Clock and framing options held in the configuration register.
   typedef struct packed {
      logic cpol;       // SCK level between frames
      logic cpha;       // 1: sample on even edges
      logic lsb_first;  // 1: bit 0 travels first
   } spi_mode_t;

   localparam spi_mode_t MODE_RESET = '{cpol: 1'b0, cpha: 1'b0, lsb_first: 1'b0};

endpackage

// File: rtl/spi_dbuf_clkdiv.sv
// Half-period timer: pulses tick every 2^psc_sel clocks while run is high.
module spi_dbuf_clkdiv #(
   parameter int PSC_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PSC_W-1:0] psc_sel,
   output logic             tick
);

   localparam int CNT_W = (1 << PSC_W) - 1;

   generate
      if (PSC_W < 1 || PSC_W > 4) begin : g_bad_psc
         $error("spi_dbuf_clkdiv: PSC_W must lie in 1..4");
      end
   endgenerate

   logic [CNT_W:0] half_len;
   logic [CNT_W:0] cnt_q;

   assign half_len = {{CNT_W{1'b0}}, 1'b1} << psc_sel;
   assign tick     = run && (cnt_q == half_len - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!run || tick) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end

   // R3: above divide-by-2, two ticks never come in adjacent cycles
   assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && psc_sel != '0) |=> !tick);

endmodule

// File: rtl/spi_dbuf_shifter.sv
// Shift engine: owns SCK, MOSI and the receive shift register for one frame.
module spi_dbuf_shifter
   import spi_dbuf_pkg::*;
#(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  spi_mode_t         mode,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic              tick,
   input  logic              miso,
   output logic              sck,
   output logic              mosi,
   output logic              busy,
   output logic              last_tick,
   output logic [WORD_W-1:0] rx_word
);

   localparam int EDGES  = 2 * WORD_W;
   localparam int EDGE_W = $clog2(EDGES);
   localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("spi_dbuf_shifter: WORD_W must be at least 2");
      end
   endgenerate

   logic [EDGE_W-1:0] edge_q;
   logic [WORD_W-1:0] tx_sh, rx_sh, rx_shifted, tx_shifted;
   logic              sample_edge, drive_edge;

   // Edge index is even on leading edges, odd on trailing edges.
   assign sample_edge = mode.cpha ? edge_q[0] : ~edge_q[0];
   assign drive_edge  = ~sample_edge && !(mode.cpha && edge_q == '0);
   assign last_tick   = busy && tick && (edge_q == LAST_EDGE);

   assign rx_shifted = mode.lsb_first ? {miso, rx_sh[WORD_W-1:1]}
                                      : {rx_sh[WORD_W-2:0], miso};
   assign tx_shifted = mode.lsb_first ? {1'b0, tx_sh[WORD_W-1:1]}
                                      : {tx_sh[WORD_W-2:0], 1'b0};
   assign rx_word    = (tick && sample_edge) ? rx_shifted : rx_sh;
   assign mosi       = mode.lsb_first ? tx_sh[0] : tx_sh[WORD_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         sck    <= 1'b0;
         edge_q <= '0;
         tx_sh  <= '0;
         rx_sh  <= '0;
      end else if (!en) begin
         busy <= 1'b0;
         sck  <= mode.cpol;
      end else if (load) begin
         busy   <= 1'b1;
         sck    <= mode.cpol;
         edge_q <= '0;
         tx_sh  <= load_word;
      end else if (busy && tick) begin
         sck    <= ~sck;
         edge_q <= edge_q + 1'b1;
         if (sample_edge) rx_sh <= rx_shifted;
         if (drive_edge)  tx_sh <= tx_shifted;
         if (edge_q == LAST_EDGE) busy <= 1'b0;
      end else if (!busy) begin
         sck <= mode.cpol;
      end
   end

   // R2: with no frame running and polarity settled, SCK sits at idle level
   assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy) && $stable(mode.cpol)) |-> (sck == mode.cpol));

   // R8: SCK is back at idle level when a frame ends without reload
   assert_end_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (sck == mode.cpol));

endmodule

// File: rtl/spi_dbuf_master.sv
// Double-buffered SPI master: holding register, shift engine, receive register.
module spi_dbuf_master
   import spi_dbuf_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int PSC_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              cfg_we,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic              cfg_lsb_first,
   input  logic [PSC_W-1:0]  cfg_psc,
   input  logic              tx_we,
   input  logic [WORD_W-1:0] tx_data,
   input  logic              rx_re,
   output logic [WORD_W-1:0] rx_data,
   input  logic              cs_sel,
   output logic              cs_n,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   output logic              tx_empty,
   output logic              rx_full,
   output logic              busy
);

   generate
      if (WORD_W < 2 || WORD_W > 32) begin : g_bad_word
         $error("spi_dbuf_master: WORD_W must lie in 2..32");
      end
      if (PSC_W < 1 || PSC_W > 4) begin : g_bad_psc
         $error("spi_dbuf_master: PSC_W must lie in 1..4");
      end
   endgenerate

   spi_mode_t         mode_q;
   logic [PSC_W-1:0]  psc_q;
   logic [WORD_W-1:0] hold_q;
   logic [WORD_W-1:0] rx_word;
   logic              tick, last_tick, load, done;

   assign load = en && !tx_empty && (!busy || last_tick);
   assign done = en && last_tick;

   // Configuration: locked while enabled.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RESET;
         psc_q  <= '0;
      end else if (cfg_we && !en) begin
         mode_q <= '{cpol: cfg_cpol, cpha: cfg_cpha, lsb_first: cfg_lsb_first};
         psc_q  <= cfg_psc;
      end
   end

   // Holding register; a host write takes priority over the load that empties it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q   <= '0;
         tx_empty <= 1'b1;
      end else if (tx_we) begin
         hold_q   <= tx_data;
         tx_empty <= 1'b0;
      end else if (load) begin
         tx_empty <= 1'b1;
      end
   end

   // Receive register; a completing frame takes priority over a read.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data <= '0;
         rx_full <= 1'b0;
      end else if (done) begin
         rx_data <= rx_word;
         rx_full <= 1'b1;
      end else if (rx_re) begin
         rx_full <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_n <= 1'b1;
      else        cs_n <= ~cs_sel;
   end

   spi_dbuf_clkdiv #(.PSC_W(PSC_W)) i_clkdiv (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .psc_sel (psc_q),
      .tick    (tick)
   );

   spi_dbuf_shifter #(.WORD_W(WORD_W)) i_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .mode      (mode_q),
      .load      (load),
      .load_word (hold_q),
      .tick      (tick),
      .miso      (miso),
      .sck       (sck),
      .mosi      (mosi),
      .busy      (busy),
      .last_tick (last_tick),
      .rx_word   (rx_word)
   );

   // R7: a frame starts with the holding register already marked empty
   assert_empty_on_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && !$past(tx_we)) |-> tx_empty);

   // R8: a frame that ends while enabled leaves a word to read
   assert_done_has_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && $past(en)) |-> rx_full);

   // R9: a queued word keeps the engine busy across the frame boundary
   assert_no_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && last_tick && !tx_empty && !tx_we) |=> busy);

   // R11: configuration cannot move while the engine was enabled
   assert_cfg_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(en) |-> ($stable(mode_q) && $stable(psc_q)));

   // R12: chip select follows the software bit one cycle later
   assert_cs_follow_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (cs_n == !$past(cs_sel)));

endmodule

// File: tb/test_spi_dbuf_master.sv
module test_spi_dbuf_master;

   localparam int CLK_PERIOD = 10;
   localparam int WORD_W     = 8;
   localparam int PSC_W      = 3;
   localparam int WD_LIMIT   = 100000;
   localparam int NVEC       = 8;

   // {cpol, cpha, lsb, psc[2:0], two_words, tx0, tx1, slave0, slave1}
   localparam logic [38:0] VECS [0:NVEC-1] = '{
      {1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 8'hA5, 8'h00, 8'h3C, 8'h00},
      {1'b0, 1'b1, 1'b0, 3'd1, 1'b0, 8'h96, 8'h00, 8'hC3, 8'h00},
      {1'b1, 1'b0, 1'b1, 3'd2, 1'b0, 8'h81, 8'h00, 8'h7E, 8'h00},
      {1'b1, 1'b1, 1'b1, 3'd0, 1'b0, 8'h4D, 8'h00, 8'hB2, 8'h00},
      {1'b0, 1'b1, 1'b1, 3'd3, 1'b1, 8'h12, 8'h34, 8'h56, 8'h78},
      {1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 8'hF0, 8'h0F, 8'h5A, 8'hA5},
      {1'b0, 1'b0, 1'b0, 3'd7, 1'b0, 8'hE7, 8'h00, 8'h18, 8'h00},
      {1'b1, 1'b1, 1'b0, 3'd1, 1'b1, 8'h01, 8'h80, 8'hFF, 8'h00}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              en = 1'b0;
   logic              cfg_we = 1'b0;
   logic              cfg_cpol = 1'b0;
   logic              cfg_cpha = 1'b0;
   logic              cfg_lsb_first = 1'b0;
   logic [PSC_W-1:0]  cfg_psc = '0;
   logic              tx_we = 1'b0;
   logic [WORD_W-1:0] tx_data = '0;
   logic              rx_re = 1'b0;
   logic [WORD_W-1:0] rx_data;
   logic              cs_sel = 1'b0;
   logic              cs_n, sck, mosi;
   logic              miso = 1'b0;
   logic              tx_empty, rx_full, busy;

   int n_vec = 0;
   int n_bad = 0;

   // slave model state, owned by the main process
   logic        sck_prev, mosi_prev;
   logic [63:0] stream, cap;
   int          edges, gap, bad_gap, ncap, bptr, exp_half;
   logic        cur_cpha;

   spi_dbuf_master #(.WORD_W(WORD_W), .PSC_W(PSC_W)) i_spi_dbuf_master (
      .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_cpol(cfg_cpol),
      .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first), .cfg_psc(cfg_psc),
      .tx_we(tx_we), .tx_data(tx_data), .rx_re(rx_re), .rx_data(rx_data),
      .cs_sel(cs_sel), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso),
      .tx_empty(tx_empty), .rx_full(rx_full), .busy(busy)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<%0d", WD_LIMIT, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec + 1, n_bad + 1);
      $finish;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One cycle: advance to the falling edge and play the slave side.
   task automatic step();
      @(negedge clk);
      gap++;
      if (sck !== sck_prev) begin
         if (edges > 0 && gap != exp_half) bad_gap++;
         gap = 0;
         if (((edges % 2) == 0) == (cur_cpha == 1'b0)) begin
            if (ncap < 64) cap[ncap] = mosi_prev;
            ncap++;
         end else begin
            if (bptr < 64) miso = stream[bptr];
            bptr++;
         end
         edges++;
      end
      sck_prev  = sck;
      mosi_prev = mosi;
   endtask

   task automatic arm_slave(input logic cpha, input int psc,
                            input logic [7:0] s0, input logic [7:0] s1, input logic lsb);
      for (int i = 0; i < 8; i++) begin
         stream[i]     = lsb ? s0[i] : s0[7-i];
         stream[8 + i] = lsb ? s1[i] : s1[7-i];
      end
      stream[63:16] = '0;
      cap       = '0;
      sck_prev  = sck;
      mosi_prev = mosi;
      edges = 0; gap = 0; bad_gap = 0; ncap = 0;
      exp_half = 1 << psc;
      cur_cpha = cpha;
      if (!cpha) begin
         miso = stream[0];
         bptr = 1;
      end else begin
         bptr = 0;
      end
   endtask

   function automatic logic [7:0] wire_word(input int base, input logic lsb, input logic [63:0] b);
      logic [7:0] w;
      for (int i = 0; i < 8; i++) begin
         if (lsb) w[i] = b[base + i];
         else     w[7 - i] = b[base + i];
      end
      return w;
   endfunction

   task automatic configure(input logic cpol, input logic cpha, input logic lsb, input logic [2:0] psc);
      en = 1'b0;
      cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsb; cfg_psc = psc;
      cfg_we = 1'b1;
      step();
      cfg_we = 1'b0;
   endtask

   task automatic run_vec(input logic [38:0] v);
      logic       cpol, cpha, lsb, two;
      logic [2:0] psc;
      logic [7:0] tx0, tx1, s0, s1, got0;
      logic       got0_ok;
      int         guard;
      {cpol, cpha, lsb, psc, two, tx0, tx1, s0, s1} = v;
      configure(cpol, cpha, lsb, psc);
      en = 1'b1; cs_sel = 1'b1;
      step(); step();
      chk("R2 idle level", 32'(sck), 32'(cpol));
      chk("R12 cs asserted", 32'(cs_n), 32'd0);
      arm_slave(cpha, int'(psc), s0, s1, lsb);
      tx_data = tx0; tx_we = 1'b1;
      step();
      tx_we = 1'b0;
      chk("R10 write clears empty", 32'(tx_empty), 32'd0);
      step();
      chk("R7 empty on load", 32'(tx_empty), 32'd1);
      chk("R7 busy at load", 32'(busy), 32'd1);
      chk("R7 no edge yet", 32'(edges), 32'd0);
      if (two) begin
         tx_data = tx1; tx_we = 1'b1;
         step();
         tx_we = 1'b0;
      end
      got0 = '0; got0_ok = 1'b0; guard = 0;
      while (busy && guard < 5000) begin
         if (two && rx_full && !got0_ok) begin
            got0 = rx_data; got0_ok = 1'b1;
            rx_re = 1'b1;
            step();
            rx_re = 1'b0;
         end else begin
            step();
         end
         guard++;
      end
      chk("R8 rx_full at end", 32'(rx_full), 32'd1);
      chk("R8 sck idle at end", 32'(sck), 32'(cpol));
      chk("R8 R9 edge count", 32'(edges), two ? 32'd32 : 32'd16);
      chk("R3 R9 edge spacing errors", 32'(bad_gap), 32'd0);
      chk("R4 R5 mosi word0", 32'(wire_word(0, lsb, cap)), 32'(tx0));
      if (two) begin
         chk("R9 R5 mosi word1", 32'(wire_word(8, lsb, cap)), 32'(tx1));
         chk("R6 rx word0", 32'(got0), 32'(s0));
         chk("R6 rx word1", 32'(rx_data), 32'(s1));
      end else begin
         chk("R6 rx word", 32'(rx_data), 32'(s0));
      end
      rx_re = 1'b1;
      step();
      rx_re = 1'b0;
      chk("R10 read clears rx_full", 32'(rx_full), 32'd0);
      cs_sel = 1'b0;
      step();
      chk("R12 cs released", 32'(cs_n), 32'd1);
   endtask

   initial begin
      arm_slave(1'b0, 0, 8'h00, 8'h00, 1'b0);
      step(); step();
      rst_n = 1'b1;
      step();
      chk("R1 cs_n", 32'(cs_n), 32'd1);
      chk("R1 sck", 32'(sck), 32'd0);
      chk("R1 tx_empty", 32'(tx_empty), 32'd1);
      chk("R1 rx_full", 32'(rx_full), 32'd0);
      chk("R1 busy", 32'(busy), 32'd0);

      for (int k = 0; k < NVEC; k++) run_vec(VECS[k]);

      // R11: configuration write while enabled is dropped
      configure(1'b1, 1'b0, 1'b0, 3'd3);
      en = 1'b1;
      step();
      cfg_cpol = 1'b0; cfg_psc = 3'd0; cfg_we = 1'b1;
      step();
      cfg_we = 1'b0;
      step(); step();
      chk("R11 idle level kept", 32'(sck), 32'd1);
      arm_slave(1'b0, 3, 8'h69, 8'h00, 1'b0);
      tx_data = 8'hC6; tx_we = 1'b1;
      step();
      tx_we = 1'b0;
      for (int g = 0; g < 400 && (busy || edges == 0); g++) step();
      chk("R11 rate kept", 32'(bad_gap), 32'd0);
      chk("R11 frame edges", 32'(edges), 32'd16);
      chk("R11 mosi word", 32'(wire_word(0, 1'b0, cap)), 32'h0000_00C6);
      rx_re = 1'b1;
      step();
      rx_re = 1'b0;

      // R13: dropping enable abandons the frame
      arm_slave(1'b0, 3, 8'h00, 8'h00, 1'b0);
      tx_data = 8'h3B; tx_we = 1'b1;
      step();
      tx_we = 1'b0;
      for (int g = 0; g < 200 && edges < 3; g++) step();
      chk("R13 busy mid frame", 32'(busy), 32'd1);
      en = 1'b0;
      step();
      chk("R13 busy after abort", 32'(busy), 32'd0);
      chk("R13 sck idle after abort", 32'(sck), 32'd1);
      chk("R13 word not returned", 32'(tx_empty), 32'd1);
      chk("R13 no received word", 32'(rx_full), 32'd0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule